// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked system read and write a 64K x 8 asynchronous static RAM. On the system side it accepts one access at a time through a valid/ready request carrying a direction flag, a 16-bit address and a write byte. When the access is finished it pulses a done flag, and for a read it presents the captured byte. On the memory side it drives every pin of the RAM from registers: the address, an active-low and an active-high chip select, an active-low output enable, an active-low write enable and a shared 8-bit tri-state data bus.

Each analogue timing interval of the RAM is turned into a whole number of clock cycles at elaboration. The conversion rounds up and uses the clock period and a speed-grade parameter (fast or slow). A write is a setup phase with the chip selected, then a write-enable pulse while the controller drives the bus, then a hold phase in which the bus is still driven after write enable rises. A read keeps select and output enable low for the longer of the cycle time, the address access time and the output-enable access time. After a read the chip stays deselected long enough for the RAM to release the bus.

A retention input puts the chip into a power-down hold. Both chip selects are driven inactive and requests are refused. When the input drops, the controller waits out a long recovery interval before it accepts the next request.

Top module: `sram_access_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, the chip is deselected (active-low select 1, active-high select 0), output enable and write enable are both 1, done is 0 and ready is 1.
- R2: A write selects the chip and applies the address for SETUP = max(1, ceil(Taw/T) - PULSE) cycles with write enable high. Write enable is then low for PULSE = max(ceil(Twp/T), ceil(Tdw/T)) cycles while the controller drives the write byte. The byte stays driven for HOLD cycles after write enable rises, and write enable is low only while the chip is selected.
- R3: During a write the chip is selected and the address held for SETUP + PULSE + HOLD cycles, which is at least ceil(Twc/T). Output enable stays high throughout. At T = 10 ns on the fast grade this gives SETUP 1, PULSE 4, HOLD 1 and 6 selected cycles.
- R4: A read holds select and output enable low, with the address stable, for RD = max(ceil(Trc/T), ceil(Taa/T), ceil(Toe/T)) cycles. The bus is sampled on the last clock edge of that window and the byte appears on the read-data output together with done. At T = 10 ns on the fast grade, RD is 6.
- R5: Output enable is never low while write enable is low or while the controller drives the bus. After a read, ready stays low for REL = max(1, ceil(Thz/T)) cycles, counting the cycle in which done is high, so that no access follows sooner. At T = 10 ns on the fast grade, REL is 2.
- R6: A read returns the byte most recently written to that address, including after a retention period.
- R7: Done is high for exactly one cycle per access. The read data holds its value until the next read completes.
- R8: Ready is low from the cycle after a request is accepted until the access ends. A request is taken only when valid and ready are both high.
- R9: While the retention input is high and no request is being accepted, the controller enters retention. Both selects are inactive, ready is low, and requests presented during retention cause no access and change no stored data.
- R10: After the retention input falls, ready stays low for REC = ceil(Trec/T) cycles with the chip deselected, then rises. If the input rises again during that wait, the controller goes back to retention.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_done | output | 1 | One-cycle pulse at the end of an access |
| rsp_rdata | output | 8 | Byte captured by the last read |
| ret_req | input | 1 | Retention (power-down hold) request |
| mem_addr | output | 16 | Address pins of the RAM |
| mem_dq | inout | 8 | Bidirectional data bus of the RAM |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |

## Verification
The access engine is driven with a vector table of mixed writes and reads. The table includes back-to-back writes, a read straight after a write, and reads of addresses whose upper bytes differ. A write-to-read pair shows whether the bus is released in time. A read-to-read pair measures the deselect gap. Distinct addresses with the same low byte content catch address-bit and data-capture faults. The pins are sampled every cycle to measure the setup, pulse, hold and output-enable windows against the cycle counts above. A retention sequence, with a request presented during it, tells a correctly refused request from one that leaks through, and shows the recovery wait at its exact length.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_READ,
    ST_RREL,
    ST_RETAIN,
    ST_RECOVER
  } ctrl_state_e;

  // Pin command for the cycle that follows the next clock edge.
  typedef struct packed {
    logic sel;
    logic oe;
    logic we;
    logic drv;
  } pin_cmd_t;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last = (cnt == W'(1));

  // Supports R2/R4/R10: an expired timer stays expired until reloaded.
  a_r10_timer_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/sram_pin_driver.sv
`timescale 1ns/1ps
module sram_pin_driver
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  pin_cmd_t          cmd,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              dq_drv,
  output logic [DATA_W-1:0] dq_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_sel_n <= 1'b1;
      mem_sel   <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      dq_drv    <= 1'b0;
      mem_addr  <= '0;
      dq_out    <= '0;
    end else begin
      mem_sel_n <= !cmd.sel;
      mem_sel   <= cmd.sel;
      mem_oe_n  <= !cmd.oe;
      mem_we_n  <= !cmd.we;
      dq_drv    <= cmd.drv;
      if (ld) begin
        mem_addr <= ld_addr;
        dq_out   <= ld_data;
      end
    end
  end

  a_r2_we_inside_select: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_sel_n && mem_sel));

  a_r5_no_oe_while_driving: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!dq_drv && mem_we_n));

endmodule

// File: rtl/sram_access_ctrl.sv
`timescale 1ns/1ps
module sram_access_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int CLK_NS      = 10,
  parameter bit FAST_GRADE  = 1'b1,
  parameter int RECOVERY_NS = 5000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              ret_req,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_oe_n,
  output logic              mem_we_n
);

  // Grade-dependent intervals in ns.
  localparam int T_WC = FAST_GRADE ? 55 : 70;
  localparam int T_WP = FAST_GRADE ? 40 : 50;
  localparam int T_AW = FAST_GRADE ? 45 : 60;
  localparam int T_DW = FAST_GRADE ? 25 : 30;
  localparam int T_RC = FAST_GRADE ? 55 : 70;
  localparam int T_AA = FAST_GRADE ? 55 : 70;
  localparam int T_OE = FAST_GRADE ? 25 : 35;
  localparam int T_HZ = FAST_GRADE ? 20 : 25;

  // Whole-cycle phase lengths.
  localparam int PULSE_C = imax(cdiv(T_WP, CLK_NS), cdiv(T_DW, CLK_NS));
  localparam int SETUP_C = imax(1, cdiv(T_AW, CLK_NS) - PULSE_C);
  localparam int HOLD_C  = imax(1, cdiv(T_WC, CLK_NS) - SETUP_C - PULSE_C);
  localparam int RD_C    = imax(imax(cdiv(T_RC, CLK_NS), cdiv(T_AA, CLK_NS)),
                                cdiv(T_OE, CLK_NS));
  localparam int REL_C   = imax(1, cdiv(T_HZ, CLK_NS));
  localparam int REC_C   = imax(1, cdiv(RECOVERY_NS, CLK_NS));
  localparam int PH_MAX  = imax(imax(imax(SETUP_C, PULSE_C), imax(HOLD_C, RD_C)), REL_C);
  localparam int PH_W    = $clog2(PH_MAX + 1);
  localparam int REC_W   = $clog2(REC_C + 1);

  ctrl_state_e       state, state_d;
  pin_cmd_t          cmd_d;
  logic              accept;
  logic              ph_last, rec_last;
  logic [PH_W-1:0]   ph_val;
  logic              dq_drv;
  logic [DATA_W-1:0] dq_out;

  assign accept = req_valid && req_ready;

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE: begin
        if (accept)       state_d = req_write ? ST_WSETUP : ST_READ;
        else if (ret_req) state_d = ST_RETAIN;
      end
      ST_WSETUP:  if (ph_last) state_d = ST_WPULSE;
      ST_WPULSE:  if (ph_last) state_d = ST_WHOLD;
      ST_WHOLD:   if (ph_last) state_d = ST_IDLE;
      ST_READ:    if (ph_last) state_d = ST_RREL;
      ST_RREL:    if (ph_last) state_d = ST_IDLE;
      ST_RETAIN:  if (!ret_req) state_d = ST_RECOVER;
      ST_RECOVER: begin
        if (ret_req)       state_d = ST_RETAIN;
        else if (rec_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    case (state_d)
      ST_WSETUP: ph_val = PH_W'(SETUP_C);
      ST_WPULSE: ph_val = PH_W'(PULSE_C);
      ST_WHOLD:  ph_val = PH_W'(HOLD_C);
      ST_READ:   ph_val = PH_W'(RD_C);
      ST_RREL:   ph_val = PH_W'(REL_C);
      default:   ph_val = '0;
    endcase
  end

  always_comb begin
    cmd_d.sel = (state_d == ST_WSETUP) || (state_d == ST_WPULSE) ||
                (state_d == ST_WHOLD)  || (state_d == ST_READ);
    cmd_d.oe  = (state_d == ST_READ);
    cmd_d.we  = (state_d == ST_WPULSE);
    cmd_d.drv = (state_d == ST_WPULSE) || (state_d == ST_WHOLD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_ready <= 1'b1;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      state     <= state_d;
      req_ready <= (state_d == ST_IDLE);
      rsp_done  <= ((state == ST_READ) || (state == ST_WHOLD)) && ph_last;
      if ((state == ST_READ) && ph_last) rsp_rdata <= mem_dq;
    end
  end

  sram_phase_timer #(.W(PH_W)) u_phase_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (state_d != state),
    .load_val (ph_val),
    .last     (ph_last)
  );

  sram_phase_timer #(.W(REC_W)) u_rec_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     ((state_d == ST_RECOVER) && (state != ST_RECOVER)),
    .load_val (REC_W'(REC_C)),
    .last     (rec_last)
  );

  sram_pin_driver #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd_d),
    .ld        (accept),
    .ld_addr   (req_addr),
    .ld_data   (req_wdata),
    .mem_addr  (mem_addr),
    .mem_sel_n (mem_sel_n),
    .mem_sel   (mem_sel),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .dq_drv    (dq_drv),
    .dq_out    (dq_out)
  );

  assign mem_dq = dq_drv ? dq_out : {DATA_W{1'bz}};

  // Checker counters for window lengths.
  logic [PH_W:0]  we_run;
  logic [REC_W:0] rec_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_run  <= '0;
      rec_run <= '0;
    end else begin
      we_run  <= !mem_we_n ? we_run + 1'b1 : '0;
      rec_run <= (state == ST_RECOVER) ? rec_run + 1'b1 : '0;
    end
  end

  a_r2_pulse_length: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_run >= (PH_W+1)'(PULSE_C)));

  a_r2_data_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> dq_drv);

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  a_r9_retain_deselected: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RETAIN) |-> (mem_sel_n && !mem_sel && !req_ready));

  a_r10_recovery_length: assert property (@(posedge clk) disable iff (rst)
    ($rose(req_ready) && $past(state) == ST_RECOVER) |-> (rec_run >= (REC_W+1)'(REC_C)));

  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);

endmodule

// File: tb/sram_access_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_access_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  // Expected phase lengths at 10 ns, fast grade, 300 ns recovery.
  localparam int E_SETUP = 1;
  localparam int E_PULSE = 4;
  localparam int E_HOLD  = 1;
  localparam int E_WSEL  = 6;
  localparam int E_RD    = 6;
  localparam int E_REL   = 2;
  localparam int E_REC   = 30;

  // {write, addr, wdata, expected read byte}
  localparam logic [32:0] VEC [8] = '{
    {1'b1, 16'h0012, 8'hA5, 8'h00},
    {1'b1, 16'h00FF, 8'h3C, 8'h00},
    {1'b0, 16'h0012, 8'h00, 8'hA5},
    {1'b1, 16'h1234, 8'h0F, 8'h00},
    {1'b0, 16'h00FF, 8'h00, 8'h3C},
    {1'b0, 16'h1234, 8'h00, 8'h0F},
    {1'b1, 16'h0012, 8'h5A, 8'h00},
    {1'b0, 16'h0012, 8'h00, 8'h5A}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, ret_req;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready, rsp_done;
  logic [7:0]  rsp_rdata;
  logic [15:0] mem_addr;
  wire  [7:0]  mem_dq;
  logic        mem_sel_n, mem_sel, mem_oe_n, mem_we_n;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = !clk;

  sram_access_ctrl #(.CLK_NS(CLK_PERIOD), .FAST_GRADE(1'b1), .RECOVERY_NS(300)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .ret_req(ret_req),
    .mem_addr(mem_addr), .mem_dq(mem_dq), .mem_sel_n(mem_sel_n),
    .mem_sel(mem_sel), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
  );

  // Behavioural RAM (low address byte only).
  logic [7:0] model_mem [256];
  logic       mdl_rd, ovl, ovl_q;
  logic [7:0] wr_a, wr_d;
  assign mdl_rd = !mem_sel_n && mem_sel && !mem_oe_n && mem_we_n;
  assign ovl    = !mem_sel_n && mem_sel && !mem_we_n;
  assign mem_dq = mdl_rd ? model_mem[mem_addr[7:0]] : 8'bz;

  initial begin
    for (int i = 0; i < 256; i++) model_mem[i] = 8'h00;
    ovl_q = 1'b0;
    wr_a  = 8'h00;
    wr_d  = 8'h00;
  end

  always @(posedge clk) begin
    ovl_q <= ovl;
    if (ovl) begin
      wr_a <= mem_addr[7:0];
      wr_d <= mem_dq;
    end
    if (ovl_q && !ovl) model_mem[wr_a] <= wr_d;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic wr, input logic [15:0] a, input logic [7:0] d,
                        input logic [7:0] e);
    int pre, we_lo, oe_lo, hold, sel_cyc, busy_bad, addr_bad, dat_bad, oe_we, rel;
    bit seen_we, sel_now;
    pre = 0; we_lo = 0; oe_lo = 0; hold = 0; sel_cyc = 0; busy_bad = 0;
    addr_bad = 0; dat_bad = 0; oe_we = 0; rel = 0; seen_we = 1'b0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_done) begin
      sel_now = !mem_sel_n && mem_sel;
      if (sel_now) begin
        sel_cyc++;
        if (mem_addr !== a) addr_bad++;
      end
      if (req_ready) busy_bad++;
      if (!mem_we_n) begin
        we_lo++; seen_we = 1'b1;
        if (mem_dq !== d) dat_bad++;
      end else if (sel_now && !seen_we && wr) begin
        pre++;
      end else if (sel_now && seen_we) begin
        hold++;
        if (mem_dq !== d) dat_bad++;
      end
      if (!mem_oe_n) begin
        oe_lo++;
        if (!mem_we_n) oe_we++;
      end
      @(negedge clk);
    end
    chk("R8", "ready high while busy", busy_bad, 0);
    if (wr) begin
      chk("R2", "setup cycles", pre, E_SETUP);
      chk("R2", "write pulse cycles", we_lo, E_PULSE);
      chk("R2", "hold cycles", hold, E_HOLD);
      chk("R2", "write data mismatches", dat_bad, 0);
      chk("R3", "selected cycles", sel_cyc, E_WSEL);
      chk("R3", "address mismatches", addr_bad, 0);
      chk("R3", "oe low during write", oe_lo, 0);
      chk("R8", "ready with write done", int'(req_ready), 1);
      @(negedge clk);
      chk("R7", "done second cycle", int'(rsp_done), 0);
    end else begin
      chk("R4", "oe low cycles", oe_lo, E_RD);
      chk("R4", "selected cycles", sel_cyc, E_RD);
      chk("R4", "address mismatches", addr_bad, 0);
      chk("R5", "oe low with we low", oe_we, 0);
      chk("R5", "we low in read", we_lo, 0);
      chk("R6", "read data", int'(rsp_rdata), int'(e));
      if (!req_ready) rel = 1;
      @(negedge clk);
      chk("R7", "done second cycle", int'(rsp_done), 0);
      chk("R7", "read data held", int'(rsp_rdata), int'(e));
      while (!req_ready) begin
        rel++;
        @(negedge clk);
      end
      chk("R5", "deselect gap after read", rel, E_REL);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt, bad;
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; ret_req = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1", "sel_n in reset", int'(mem_sel_n), 1);
    chk("R1", "sel in reset", int'(mem_sel), 0);
    chk("R1", "oe_n/we_n in reset", int'(mem_oe_n && mem_we_n), 1);
    chk("R1", "done in reset", int'(rsp_done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "ready after reset", int'(req_ready), 1);
    chk("R1", "pins idle after reset", int'(mem_sel_n && !mem_sel && mem_oe_n && mem_we_n), 1);

    for (int i = 0; i < 8; i++)
      run_op(VEC[i][32], VEC[i][31:16], VEC[i][15:8], VEC[i][7:0]);

    // Retention with a request offered during it (R9).
    ret_req = 1'b1;
    @(negedge clk);
    chk("R9", "ready in retention", int'(req_ready), 0);
    chk("R9", "deselected in retention", int'(mem_sel_n && !mem_sel), 1);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0012; req_wdata = 8'hEE;
    bad = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (!mem_sel_n || mem_sel || !mem_we_n || req_ready) bad++;
    end
    chk("R9", "access during retention", bad, 0);
    req_valid = 1'b0;
    ret_req = 1'b0;

    // Recovery wait (R10).
    cnt = 0; bad = 0;
    @(negedge clk);
    while (!req_ready) begin
      cnt++;
      if (!mem_sel_n || mem_sel) bad++;
      @(negedge clk);
    end
    chk("R10", "recovery cycles", cnt, E_REC);
    chk("R10", "selected in recovery", bad, 0);

    run_op(1'b0, 16'h0012, 8'h00, 8'h5A);
    run_op(1'b0, 16'h1234, 8'h00, 8'h0F);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule